// File: doc/BRIEF.md
# Radix-4 Signed-Digit to Binary Converter

This block turns an eight-digit radix-4 signed-digit number into a 17-bit two's complement integer. Each digit is a 3-bit two's complement field that may hold -3 to +3. Digits of different signs may appear in the same word, because the representation is redundant. The value of the word is the sum of each digit times four raised to the digit's position.

A caller raises `startIn` for one cycle while the block is idle and presents all eight digits on `digitsIn`. The block copies the digits and runs a Horner accumulation, one digit per cycle, starting from the most significant digit (`acc = 4*acc + digit`). While it runs, `busyOut` is high. When it finishes, `doneOut` pulses for one cycle. The result and an error flag then stay on the outputs until the next accepted start.

The code 3'b100 (-4) lies outside the legal digit set. If any digit carries that code, `errOut` is set and the digit is still weighted as -4.

Top module: `r4sd_decoder`

## Requirements
- R1: After reset `busyOut`, `doneOut` and `errOut` are 0 and `resultOut` is 0.
- R2: If `startIn` is high at a clock edge while `busyOut` is low, `busyOut` is high after that edge and stays high for exactly 8 cycles. `doneOut` is high for the single cycle after the 9th edge counted from the accepting edge. In that same cycle `busyOut` is low.
- R3: Digit i (i = 0 is least significant) sits at `digitsIn[3i+2:3i]` in two's complement. When done, `resultOut` equals the sum of digit_i * 4^i, including words whose digits have mixed signs (for example 1,0,-2,1 from the most significant digit gives 57).
- R4: The extremes of the legal range come out exactly. All digits 3 gives 65535 and all digits -3 gives -65535. A 1 followed by seven 3s gives 32767, and a -2 followed by seven 0s gives -32768.
- R5: `errOut` is 1 when done if any digit equals 3'b100, and 0 otherwise. A 3'b100 digit is weighted as -4, and the sum is taken modulo 2^17.
- R6: `resultOut` and `errOut` keep their values after the done cycle until the next accepted start. A `startIn` pulse while `busyOut` is high is ignored: the running conversion is not disturbed and no extra done pulse follows.
- R7: `doneOut` is never high in two consecutive cycles, and it is never high together with `busyOut`.
- R8: A start raised in the cycle where `doneOut` is high is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startIn | input | 1 | Start request, accepted only when idle |
| digitsIn | input | 24 | Eight 3-bit two's complement digits, digit i at bits 3i+2:3i |
| busyOut | output | 1 | Conversion in progress |
| doneOut | output | 1 | One-cycle pulse when the result is ready |
| resultOut | output | 17 | Two's complement result |
| errOut | output | 1 | A digit held the illegal code 3'b100 |

## Verification
The hardest case to reach is a start request that arrives while a conversion is already running. The bench drives a second, different operand three cycles into a run. It then checks that the popped result still matches the first operand and that no stray done pulse appears while the expected-result queue is empty. Back-to-back acceptance is reached by raising the next start on the very cycle that done is seen. The illegal code is placed in both the lowest and the highest digit, so that the -4 weighting is checked at both ends of the accumulation.

// File: rtl/r4sd_pkg.sv
package r4sd_pkg;
  typedef struct packed {
    logic load;   // capture digits, clear accumulator
    logic step;   // fold in one digit
    logic last;   // this step is the final one
  } ctrlStrobes_t;
endpackage

// File: rtl/r4sd_ctrl.sv
module r4sd_ctrl
  import r4sd_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output ctrlStrobes_t strobes,
  output logic         busyOut,
  output logic         doneOut
);
  localparam int CNT_W = $clog2(NUM_DIGITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_DIGITS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t stateQ;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes.load = (stateQ == ST_IDLE) && startIn;
    strobes.step = (stateQ == ST_RUN);
    strobes.last = (stateQ == ST_RUN) && (stepCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strobes.last;
      if (strobes.load) begin
        stateQ  <= ST_RUN;
        stepCnt <= '0;
      end else if (strobes.step) begin
        stepCnt <= stepCnt + 1'b1;
        if (strobes.last) stateQ <= ST_IDLE;
      end
    end
  end

  assign busyOut = (stateQ == ST_RUN);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && busyOut));
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> $past(startIn));
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> $fell(busyOut));
  assert_no_load_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> !strobes.load);
endmodule

// File: rtl/r4sd_datapath.sv
module r4sd_datapath
  import r4sd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     strobes,
  input  logic [NUM_DIGITS*DIGIT_W-1:0]    digitsIn,
  output logic [2*NUM_DIGITS:0]            accOut,
  output logic                             errOut
);
  localparam int VEC_W = NUM_DIGITS * DIGIT_W;
  localparam int RES_W = 2 * NUM_DIGITS + 1;
  localparam logic [DIGIT_W-1:0] BAD_CODE = {1'b1, {(DIGIT_W-1){1'b0}}};

  logic [VEC_W-1:0]   digShift;
  logic [NUM_DIGITS-1:0] badDigit;
  logic [DIGIT_W-1:0] headDigit;
  logic [RES_W-1:0]   headExt;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_chk
    assign badDigit[gi] = (digitsIn[gi*DIGIT_W +: DIGIT_W] == BAD_CODE);
  end

  assign headDigit = digShift[VEC_W-1 -: DIGIT_W];
  assign headExt   = {{(RES_W-DIGIT_W){headDigit[DIGIT_W-1]}}, headDigit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      digShift <= '0;
      accOut   <= '0;
      errOut   <= 1'b0;
    end else if (strobes.load) begin
      digShift <= digitsIn;
      accOut   <= '0;
      errOut   <= |badDigit;
    end else if (strobes.step) begin
      digShift <= digShift << DIGIT_W;
      accOut   <= {accOut[RES_W-3:0], 2'b00} + headExt;
    end
  end

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(accOut));
  assert_hold_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(errOut));
  assert_legal_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.last) && !errOut) |-> (accOut != {1'b1, {(RES_W-1){1'b0}}}));
endmodule

// File: rtl/r4sd_decoder.sv
module r4sd_decoder
  import r4sd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_W    = 3,
  localparam int VEC_W     = NUM_DIGITS * DIGIT_W,
  localparam int RES_W     = 2 * NUM_DIGITS + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [VEC_W-1:0] digitsIn,
  output logic             busyOut,
  output logic             doneOut,
  output logic [RES_W-1:0] resultOut,
  output logic             errOut
);
  ctrlStrobes_t strobes;

  r4sd_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .strobes(strobes), .busyOut(busyOut), .doneOut(doneOut)
  );

  r4sd_datapath #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .digitsIn(digitsIn),
    .accOut(resultOut), .errOut(errOut)
  );
endmodule

// File: tb/sim_r4sd_decoder.sv
`timescale 1ns/1ps
module sim_r4sd_decoder;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [3*ND-1:0] digitsIn = '0;
  logic busyOut, doneOut, errOut;
  logic [2*ND:0] resultOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [2*ND+1:0] expQ[$];  // {err, result}

  always #2.5 clk = ~clk;

  r4sd_decoder u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .digitsIn(digitsIn),
    .busyOut(busyOut), .doneOut(doneOut), .resultOut(resultOut), .errOut(errOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3*ND-1:0] packDigits(input int d[ND]);
    logic [3*ND-1:0] p = '0;
    for (int k = 0; k < ND; k++) p[3*(ND-1-k) +: 3] = 3'(d[k]);
    return p;
  endfunction

  function automatic logic [2*ND+1:0] expectOf(input int d[ND]);
    int v = 0;
    logic e = 1'b0;
    for (int k = 0; k < ND; k++) begin
      v = v * 4 + d[k];
      if (d[k] == -4) e = 1'b1;
    end
    return {e, (2*ND+1)'(v)};
  endfunction

  // Monitor: pops expected items on each done pulse
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expQ.size() == 0) begin
        check("R6 unexpected done", 32'(doneOut), 32'd0);
      end else begin
        logic [2*ND+1:0] e;
        e = expQ.pop_front();
        check("R3/R4 result", 32'(resultOut), 32'(e[2*ND:0]));
        check("R5 err", 32'(errOut), 32'(e[2*ND+1]));
      end
    end
  end

  // Driver: called at a negedge, returns at the negedge where done is seen
  task automatic send(input int d[ND]);
    expQ.push_back(expectOf(d));
    startIn  = 1'b1;
    digitsIn = packDigits(d);
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 1; k <= ND; k++) begin
      check("R2 busy", 32'(busyOut), 32'd1);
      check("R7 no early done", 32'(doneOut), 32'd0);
      @(negedge clk);
    end
    check("R2 done timing", 32'(doneOut), 32'd1);
    check("R7 busy low at done", 32'(busyOut), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [2*ND+1:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", 32'(busyOut), 32'd0);
    check("R1 done", 32'(doneOut), 32'd0);
    check("R1 result", 32'(resultOut), 32'd0);
    check("R1 err", 32'(errOut), 32'd0);

    send('{0,0,0,0,1,0,-2,1});      // R3 57
    send('{0,0,0,0,-1,0,2,-1});     // R3 -57, R8 back to back
    send('{3,-3,2,-2,1,-1,0,3});    // R3 mixed
    send('{1,3,3,3,3,3,3,3});       // R4 32767
    send('{-2,0,0,0,0,0,0,0});      // R4 -32768
    send('{3,3,3,3,3,3,3,3});       // R4 65535
    send('{-3,-3,-3,-3,-3,-3,-3,-3}); // R4 -65535
    send('{0,0,0,0,0,0,0,0});       // R3 zero

    // R6: hold after done
    send('{0,0,0,0,0,0,0,-4});      // R5 low digit illegal
    e = expectOf('{0,0,0,0,0,0,0,-4});
    repeat (5) @(negedge clk);
    check("R6 result hold", 32'(resultOut), 32'(e[2*ND:0]));
    check("R6 err hold", 32'(errOut), 32'd1);
    check("R6 idle", 32'(busyOut), 32'd0);

    send('{-4,0,0,0,0,0,0,0});      // R5 top digit illegal
    send('{0,0,1,2,3,-1,-2,-3});    // R5 err cleared by legal word

    // R6: start during busy is ignored
    expQ.push_back(expectOf('{0,0,0,0,1,0,-2,1}));
    startIn  = 1'b1;
    digitsIn = packDigits('{0,0,0,0,1,0,-2,1});
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    startIn  = 1'b1;
    digitsIn = packDigits('{3,3,3,3,3,3,3,3});
    @(negedge clk);
    startIn = 1'b0;
    repeat (12) @(negedge clk);
    check("R6 ignored start result", 32'(resultOut), 32'd57);
    check("R6 queue drained", 32'(expQ.size()), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule